// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a synchronous burst memory port. A new start address is taken from the address input when one of two active-low strobes is seen low on a rising clock edge. One strobe belongs to the processor side and the other to the memory controller side. From then on, the two low address bits come from an internal beat counter. The counter moves forward one beat on each clock edge where the active-low advance input is low. The upper address bits stay fixed.

The sequence order is chosen with a mode input when a burst is loaded. Interleaved order XORs the start bits with the beat count. Linear order adds the beat count to the start bits, modulo the burst length. With the default two counter bits, a burst has four beats. The counter then wraps, and the sequence repeats from the start address.

A strobe may be used on every cycle, which gives plain single-address operation with no idle cycle between loads. To get simple bursts, hold the processor strobe high, hold advance low, and load through the controller strobe alone.

Top module: `burst_addr_seq`

## Requirements
- R1: A load happens on a rising edge when the chip enable `ce_n` is low and either `ads_cpu_n` or `ads_ctl_n` is low. After that edge, `addr_out` equals the sampled `addr_in` and `burst_active` is 1.
- R2: While `ce_n` is high, a low `ads_cpu_n` is ignored. `addr_out` and `burst_active` keep their previous values.
- R3: A low `ads_ctl_n` while `ce_n` is high ends the burst. After that edge, `burst_active` is 0 and `addr_out` is the burst start address.
- R4: While a burst is active and no strobe acts, each edge with `adv_n` low advances the beat count by one. After four advances, `addr_out` is back at the start address.
- R5: An edge with `adv_n` high changes nothing. An edge with `adv_n` low while no burst is active also changes nothing.
- R6: With `order_ilv`=1 at load, the low two address bits are start XOR count.
- R7: With `order_ilv`=0 at load, the low two address bits are (start + count) mod 4. Bits above bit 1 equal the loaded address for the whole burst.
- R8: `order_ilv` is sampled only at a load. Changing it during a burst has no effect on that burst.
- R9: When a load and an advance fall on the same edge, the load wins and the beat count restarts at zero.
- R10: Both strobes low with `ce_n` low gives a single load. Loads on consecutive edges each take effect immediately, with no idle cycle.
- R11: While `rst_n` is low at a rising edge, `addr_out` becomes 0 and `burst_active` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External start address |
| ads_cpu_n | input | 1 | Processor-side load strobe, active low, gated by `ce_n` |
| ads_ctl_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| order_ilv | input | 1 | Order select sampled at load: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W | Current burst address |
| burst_active | output | 1 | High while a loaded burst is in progress |

## Verification
Two events can land on the same clock edge:
- a load and an advance;
- the two strobes together.

The bench provokes the first case in the middle of a burst. It drives a fresh address with `adv_n` held low and expects the new address with the count back at zero. For the second case, it drives both strobes low on consecutive edges and expects each new address at once. It also drives both strobes low with `ce_n` high and expects a deselect, not a load. Every beat is judged against an independent model of start, count and order held in the bench.

// File: rtl/bseq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package bseq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bseq_load_ctl.sv
// Module: bseq_load_ctl
// Turns the two address strobes and the chip enable into one load or one
// deselect command for the current cycle.
// Assumes: all inputs are synchronous to the sampling clock.
module bseq_load_ctl (
    input  logic ads_cpu_n,
    input  logic ads_ctl_n,
    input  logic ce_n,
    output logic do_load,
    output logic do_desel
);
    logic cpu_ok;
    logic ctl_ok;

    // Qualify each strobe: the processor strobe counts only when the chip is enabled.
    always_comb begin
        cpu_ok   = !ads_cpu_n && !ce_n;
        ctl_ok   = !ads_ctl_n && !ce_n;
        // The processor strobe takes priority; the controller strobe loads otherwise.
        do_load  = cpu_ok || ctl_ok;
        // The controller strobe with the chip disabled ends the burst.
        do_desel = !cpu_ok && !ads_ctl_n && ce_n;
    end
endmodule

// File: rtl/bseq_counter.sv
// Module: bseq_counter
// Beat counter and burst-active flag. The count clears on a load or a
// deselect, and steps on an active-low advance while a burst runs.
// Assumes: do_load and do_desel are never both high.
module bseq_counter #(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_load,
    input  logic               do_desel,
    input  logic               adv_n,
    output logic [BURST_W-1:0] cnt,
    output logic               active
);
    // Update the count and the active flag; a load takes precedence over an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (do_load) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (do_desel) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (active && !adv_n) begin
            cnt    <= cnt + BURST_W'(1);
        end
    end

    // R4: an advance with no strobe moves the count forward by one, wrapping.
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !do_load && !do_desel && !adv_n) |=> (cnt == BURST_W'($past(cnt) + 1'b1)));

    // R5: without an advance or a strobe, the count and the flag hold.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_desel && adv_n) |=> ($stable(cnt) && $stable(active)));

    // R5: an advance while idle leaves the counter untouched.
    a_r5_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !do_load && !do_desel) |=> ($stable(cnt) && !active));

    // R9: a load always restarts the count.
    a_r9_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (cnt == '0 && active));
endmodule

// File: rtl/bseq_order.sv
// Module: bseq_order
// Maps the start bits and the beat count to the low address bits, in
// linear or interleaved order.
// Assumes: the order value is held stable for the whole burst.
module bseq_order #(
    parameter int BURST_W = 2
) (
    input  bseq_pkg::burst_order_e order,
    input  logic [BURST_W-1:0]     start_lo,
    input  logic [BURST_W-1:0]     cnt,
    output logic [BURST_W-1:0]     addr_lo
);
    // Choose the sequence: XOR for interleaved, modulo add for linear.
    always_comb begin
        if (order == bseq_pkg::ORD_INTERLEAVE)
            addr_lo = start_lo ^ cnt;
        else
            addr_lo = start_lo + cnt;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Burst address sequencer. It captures a start address on a qualified
// strobe, then walks the low BURST_W bits in the order chosen at load time.
// Assumes: synchronous inputs and a synchronous active-low reset.
module burst_addr_seq #(
    parameter int ADDR_W  = 16,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ads_cpu_n,
    input  logic              ads_ctl_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);
    import bseq_pkg::*;

    localparam int HI_W = ADDR_W - BURST_W;

    logic               do_load;
    logic               do_desel;
    logic [BURST_W-1:0] cnt;
    logic [ADDR_W-1:0]  base_q;
    burst_order_e       order_q;
    logic [BURST_W-1:0] addr_lo;

    bseq_load_ctl u_load (
        .ads_cpu_n (ads_cpu_n),
        .ads_ctl_n (ads_ctl_n),
        .ce_n      (ce_n),
        .do_load   (do_load),
        .do_desel  (do_desel)
    );

    bseq_counter #(.BURST_W(BURST_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_load  (do_load),
        .do_desel (do_desel),
        .adv_n    (adv_n),
        .cnt      (cnt),
        .active   (burst_active)
    );

    // Capture the start address and the order on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (do_load) begin
            base_q  <= addr_in;
            order_q <= burst_order_e'(order_ilv);
        end
    end

    bseq_order #(.BURST_W(BURST_W)) u_ord (
        .order    (order_q),
        .start_lo (base_q[BURST_W-1:0]),
        .cnt      (cnt),
        .addr_lo  (addr_lo)
    );

    // Join the fixed upper bits and the sequenced low bits.
    always_comb begin
        addr_out = {base_q[ADDR_W-1:BURST_W], addr_lo};
    end

    // R1: a load shows the captured address on the next cycle.
    a_r1_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (addr_out == $past(addr_in) && burst_active));

    // R3: a deselect drops the active flag.
    a_r3_desel: assert property (@(posedge clk) disable iff (!rst_n)
        do_desel |=> !burst_active);

    // R7: the upper bits hold unless a load happens.
    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !do_load |=> $stable(addr_out[ADDR_W-1:BURST_W]));

    // R8: the order is fixed between loads.
    a_r8_order_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !do_load |=> $stable(order_q));

    // R10: the decoder never issues a load and a deselect together.
    a_r10_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_load, do_desel}));

    // R11: reset leaves the port idle at address zero.
    a_r11_reset: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0 && !burst_active));

    initial begin
        a_hi_width: assert (HI_W > 0);
    end
endmodule

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver updates a reference model and queues the
// expected port values; the monitor compares them after each rising edge.
module burst_addr_seq_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ads_cpu_n = 1'b1;
    logic          ads_ctl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ce_n = 1'b0;
    logic          order_ilv = 1'b1;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] q_addr[$];
    bit            q_act[$];
    string         q_tag[$];

    // Reference model state
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt  = '0;
    bit            m_ilv  = 1'b1;
    bit            m_act  = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
        .ce_n(ce_n), .order_ilv(order_ilv),
        .addr_out(addr_out), .burst_active(burst_active)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    // Drive one cycle at the falling edge, update the model and queue the expectation.
    task automatic step(input logic [AW-1:0] a, input bit cpu_n, input bit ctl_n,
                        input bit av_n, input bit cen, input bit ord, input string tag);
        bit ld, ds;
        @(negedge clk);
        addr_in = a; ads_cpu_n = cpu_n; ads_ctl_n = ctl_n;
        adv_n = av_n; ce_n = cen; order_ilv = ord;
        ld = (!cpu_n && !cen) || (!ctl_n && !cen);
        ds = !ctl_n && cen;
        if (!rst_n) begin
            m_base = '0; m_cnt = '0; m_ilv = 1'b1; m_act = 1'b0;
        end else if (ld) begin
            m_base = a; m_cnt = '0; m_ilv = ord; m_act = 1'b1;
        end else if (ds) begin
            m_cnt = '0; m_act = 1'b0;
        end else if (m_act && !av_n) begin
            m_cnt = m_cnt + 2'd1;
        end
        q_addr.push_back(model_addr());
        q_act.push_back(m_act);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(16'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_addr.size() > 0) begin
                logic [AW-1:0] ea;
                bit ev;
                string t;
                ea = q_addr.pop_front();
                ev = q_act.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (addr_out !== ea || burst_active !== ev) begin
                    fails++;
                    $display("FAIL %s: addr_out=%h active=%0b expected addr_out=%h active=%0b",
                             t, addr_out, burst_active, ea, ev);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R11: reset
        rst_n = 1'b0;
        step(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
        step(16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R11");
        @(negedge clk);
        rst_n = 1'b1;

        // R6/R7/R4: every start value in both orders, four advances then wrap
        for (int ord = 0; ord < 2; ord++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-1:0] a;
                a = 16'hA5C0 | AW'(s);
                step(a, 1'b1, 1'b0, 1'b1, 1'b0, ord[0], "R1");
                for (int b = 1; b < 4; b++)
                    step(a, 1'b1, 1'b1, 1'b0, 1'b0, ord[0], ord ? "R6" : "R7");
                step(a, 1'b1, 1'b1, 1'b0, 1'b0, ord[0], "R4");
                step(a, 1'b1, 1'b1, 1'b0, 1'b0, ord[0], "R4");
            end
        end

        // R5: hold without advance
        step(16'h3C02, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        step(16'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        step(16'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");

        // R8: order input changed mid-burst is ignored
        step(16'h7001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");

        // R9: load and advance on the same edge
        step(16'h4442, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        step(16'h9993, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");

        // R10: both strobes low, back-to-back loads every cycle
        step(16'h1111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
        step(16'h2222, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
        step(16'h3333, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
        step(16'h4445, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10");

        // R2: processor strobe ignored while chip disabled
        step(16'hBEEF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R2");
        step(16'hCAFE, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");

        // R3: controller strobe with chip disabled deselects (both strobes low too)
        step(16'hDEAD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R3");

        // R5: advance while idle has no effect
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        step(16'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");

        idle("R5");
        repeat (3) @(negedge clk);
        if (q_addr.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d results pending, expected 0", q_addr.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule